// File: doc/BRIEF.md
# Receive Status-Word Frame Splitter

This block takes one received bulk transfer and cuts it into Ethernet frames. The transfer arrives as a stream of 32-bit little-endian words, with a valid/ready handshake, a last marker on the final word and a byte-keep mask on that final word. Inside the transfer, every frame starts with a 32-bit status word. The status word carries an error flag and a 14-bit byte length. That length counts the frame's 4 trailing check bytes. Frames are packed back to back, and each one starts on a 4-byte boundary.

The output is a byte-wide stream with valid/ready, a first marker and a last marker. Only the payload is forwarded. The check bytes and the alignment padding are consumed without being sent. Any fault in the layout closes the current output frame with a single in-band abort beat. The data byte of that beat carries a cause code. After an abort, the rest of the transfer is thrown away, and parsing starts again at the next transfer.

Top module: `rxd_deframer`

## Requirements
- R1: After reset, `m_tvalid_o` is low and `s_tready_o` is high.
- R2: In a status word, bits 29:16 give the frame length L. Exactly L-4 payload bytes are forwarded in transfer order. Within each input word, bits 7:0 are the earliest byte. The first payload byte carries `m_tfirst_o`, and the final payload byte carries `m_tlast_o`. The 4 check bytes are never forwarded. Status bits 31:30 and 14:0 have no effect.
- R3: After a good frame, the next status word is the input word that follows ceil(L/4) frame words. Padding bytes are skipped, so one transfer can carry several frames.
- R4: A status word with bit 15 set forwards no payload. Instead, one abort beat is emitted with first=1, last=1, err=1 and data 0x01.
- R5: A status word is expected, but the last input word holds fewer than 4 bytes (keep count below 4). The block emits an abort beat with first=1 and data 0x02. The keep mask is valid only on the last word, with contiguous low bits set, and the count of set bits is the number of valid bytes.
- R6: The transfer ends before L bytes of the frame have followed its status word. The block emits an abort beat with data 0x03, and its last=1. No payload from the final input word is forwarded. The beat's first flag is 1 only if no payload of that frame was sent.
- R7: A length of 4 or less is a runt. The block emits an abort beat with first=1 and data 0x04.
- R8: After any abort, input words up to and including the last word are consumed with no output. The next transfer is parsed from its first word as a status word.
- R9: A transfer whose final word holds at least the bytes the last frame still needs ends cleanly, with no abort beat.
- R10: While `m_tready_i` is low, the output beat holds steady and no byte is lost. While a byte stream is pending, `s_tready_o` is low.
- R11: When several faults apply to one status word, the cause is chosen in this order: short word (0x02), then error flag (0x01), then runt (0x04), then length past the end (0x03).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_tdata_i | input | 32 | Input word, byte 0 in bits 7:0 |
| s_tkeep_i | input | 4 | Valid bytes of the last word, contiguous low bits |
| s_tvalid_i | input | 1 | Input word valid |
| s_tlast_i | input | 1 | Final word of the transfer |
| s_tready_o | output | 1 | Input word accepted when high with valid |
| m_tdata_o | output | 8 | Payload byte, or the cause code on an abort beat |
| m_tvalid_o | output | 1 | Output byte valid |
| m_tready_i | input | 1 | Output sink ready |
| m_tfirst_o | output | 1 | First beat of a frame |
| m_tlast_o | output | 1 | Final beat of a frame |
| m_terr_o | output | 1 | Abort beat marker |

## Verification
The main internal state is the count of frame bytes still to come. If that count is wrong, the next status word is read from the wrong place. The symptom shows within one frame: either a spurious abort appears, or the next frame has the wrong length and payload. A wrong first-sent flag shows on the very next abort beat or payload word, as a bad first marker. If the byte serializer stalls, `s_tready_o` stays low and expected beats go missing. If it runs ahead, the output data changes during a stall, and that is caught on the next clock.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_BODY = 2'd1,
    ST_DROP = 2'd2
  } rxd_state_e;

  localparam logic [7:0] CODE_NONE  = 8'h00;
  localparam logic [7:0] CODE_ES    = 8'h01;
  localparam logic [7:0] CODE_SHORT = 8'h02;
  localparam logic [7:0] CODE_OVR   = 8'h03;
  localparam logic [7:0] CODE_RUNT  = 8'h04;
endpackage

// File: rtl/rxd_hdr_decode.sv
module rxd_hdr_decode #(
  parameter int DATA_W    = 32,
  parameter int LEN_LSB   = 16,
  parameter int LEN_W     = 14,
  parameter int ES_BIT    = 15,
  parameter int FCS_BYTES = 4,
  parameter int WB        = DATA_W / 8,
  parameter int KC_W      = $clog2(WB + 1)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              last_i,
  input  logic [KC_W-1:0]   kcnt_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              bad_o,
  output logic [7:0]        code_o
);
  import rxd_pkg::*;

  logic short_w, es_w, runt_w;

  always_comb begin
    len_o   = word_i[LEN_LSB +: LEN_W];
    short_w = last_i && (kcnt_i < KC_W'(WB));
    es_w    = word_i[ES_BIT];
    runt_w  = len_o <= LEN_W'(FCS_BYTES);
    // priority: short word, error flag, runt, nothing after the header
    if (short_w)     code_o = CODE_SHORT;
    else if (es_w)   code_o = CODE_ES;
    else if (runt_w) code_o = CODE_RUNT;
    else if (last_i) code_o = CODE_OVR;
    else             code_o = CODE_NONE;
    bad_o = code_o != CODE_NONE;
  end
endmodule

// File: rtl/rxd_seg_plan.sv
module rxd_seg_plan #(
  parameter int LEN_W     = 14,
  parameter int FCS_BYTES = 4,
  parameter int WB        = 4,
  parameter int KC_W      = $clog2(WB + 1)
) (
  input  logic [LEN_W-1:0] rem_i,
  input  logic             last_i,
  input  logic [KC_W-1:0]  kcnt_i,
  output logic [KC_W-1:0]  n_pay_o,
  output logic             pay_last_o,
  output logic             frame_end_o,
  output logic             overrun_o,
  output logic [LEN_W-1:0] rem_next_o
);
  localparam logic [LEN_W-1:0] LEN_WB  = LEN_W'(WB);
  localparam logic [LEN_W-1:0] LEN_FCS = LEN_W'(FCS_BYTES);

  logic [LEN_W-1:0] pay_rem;
  logic [KC_W-1:0]  need;

  always_comb begin
    pay_rem     = (rem_i > LEN_FCS) ? rem_i - LEN_FCS : '0;
    need        = (rem_i > LEN_WB) ? KC_W'(WB) : KC_W'(rem_i);
    overrun_o   = last_i && ((rem_i > LEN_WB) || (kcnt_i < need));
    n_pay_o     = (pay_rem >= LEN_WB) ? KC_W'(WB) : KC_W'(pay_rem);
    pay_last_o  = (pay_rem != '0) && (pay_rem <= LEN_WB);
    frame_end_o = rem_i <= LEN_WB;
    rem_next_o  = (rem_i > LEN_WB) ? rem_i - LEN_WB : '0;
  end
endmodule

// File: rtl/rxd_byte_ser.sv
module rxd_byte_ser #(
  parameter int WB   = 4,
  parameter int KC_W = $clog2(WB + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [8*WB-1:0] ld_data_i,
  input  logic [KC_W-1:0] ld_cnt_i,
  input  logic            ld_first_i,
  input  logic            ld_last_i,
  input  logic            ld_err_i,
  output logic            ready_o,
  output logic [7:0]      m_tdata_o,
  output logic            m_tvalid_o,
  input  logic            m_tready_i,
  output logic            m_tfirst_o,
  output logic            m_tlast_o,
  output logic            m_terr_o
);
  localparam int IDX_W = (WB > 1) ? $clog2(WB) : 1;

  logic [8*WB-1:0] data_q;
  logic [KC_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic first_q, last_q, err_q;
  logic fire;

  assign m_tvalid_o = cnt_q != '0;
  assign fire       = m_tvalid_o && m_tready_i;
  assign ready_o    = (cnt_q == '0) || ((cnt_q == KC_W'(1)) && m_tready_i);
  assign m_tdata_o  = data_q[{idx_q, 3'b000} +: 8];
  assign m_tfirst_o = first_q && (idx_q == '0);
  assign m_tlast_o  = last_q && (cnt_q == KC_W'(1));
  assign m_terr_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (load_i) begin
      data_q  <= ld_data_i;
      cnt_q   <= ld_cnt_i;
      idx_q   <= '0;
      first_q <= ld_first_i;
      last_q  <= ld_last_i;
      err_q   <= ld_err_i;
    end else if (fire) begin
      cnt_q <= cnt_q - KC_W'(1);
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  // R10
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_tdata_o) &&
      $stable(m_tfirst_o) && $stable(m_tlast_o) && $stable(m_terr_o)));

  // R10
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> ready_o);
endmodule

// File: rtl/rxd_deframer.sv
module rxd_deframer #(
  parameter int DATA_W    = 32,
  parameter int LEN_LSB   = 16,
  parameter int LEN_W     = 14,
  parameter int ES_BIT    = 15,
  parameter int FCS_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic [DATA_W/8-1:0] s_tkeep_i,
  input  logic              s_tvalid_i,
  input  logic              s_tlast_i,
  output logic              s_tready_o,
  output logic [7:0]        m_tdata_o,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic              m_tfirst_o,
  output logic              m_tlast_o,
  output logic              m_terr_o
);
  import rxd_pkg::*;

  localparam int WB   = DATA_W / 8;
  localparam int KC_W = $clog2(WB + 1);

  rxd_state_e state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic sent_q, sent_d;

  logic [KC_W-1:0] kcnt;
  logic accept, ser_ready;
  logic [LEN_W-1:0] hdr_len;
  logic hdr_bad;
  logic [7:0] hdr_code;
  logic [KC_W-1:0] n_pay;
  logic pay_last, frame_end, overrun;
  logic [LEN_W-1:0] rem_next;

  logic ld;
  logic [DATA_W-1:0] ld_data;
  logic [KC_W-1:0] ld_cnt;
  logic ld_first, ld_last, ld_err;

  always_comb begin
    kcnt = '0;
    for (int b = 0; b < WB; b++) kcnt = kcnt + KC_W'(s_tkeep_i[b]);
    if (!s_tlast_i) kcnt = KC_W'(WB);
  end

  assign s_tready_o = ser_ready;
  assign accept     = s_tvalid_i && ser_ready;

  rxd_hdr_decode #(
    .DATA_W(DATA_W), .LEN_LSB(LEN_LSB), .LEN_W(LEN_W), .ES_BIT(ES_BIT),
    .FCS_BYTES(FCS_BYTES), .WB(WB), .KC_W(KC_W)
  ) u_hdr (
    .word_i(s_tdata_i), .last_i(s_tlast_i), .kcnt_i(kcnt),
    .len_o(hdr_len), .bad_o(hdr_bad), .code_o(hdr_code)
  );

  rxd_seg_plan #(
    .LEN_W(LEN_W), .FCS_BYTES(FCS_BYTES), .WB(WB), .KC_W(KC_W)
  ) u_plan (
    .rem_i(rem_q), .last_i(s_tlast_i), .kcnt_i(kcnt),
    .n_pay_o(n_pay), .pay_last_o(pay_last), .frame_end_o(frame_end),
    .overrun_o(overrun), .rem_next_o(rem_next)
  );

  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    sent_d   = sent_q;
    ld       = 1'b0;
    ld_data  = '0;
    ld_cnt   = '0;
    ld_first = 1'b0;
    ld_last  = 1'b0;
    ld_err   = 1'b0;
    if (accept) begin
      unique case (state_q)
        ST_HDR: begin
          if (hdr_bad) begin
            ld       = 1'b1;
            ld_data  = DATA_W'(hdr_code);
            ld_cnt   = KC_W'(1);
            ld_first = 1'b1;
            ld_last  = 1'b1;
            ld_err   = 1'b1;
            state_d  = s_tlast_i ? ST_HDR : ST_DROP;
          end else begin
            rem_d   = hdr_len;
            sent_d  = 1'b0;
            state_d = ST_BODY;
          end
        end
        ST_BODY: begin
          if (overrun) begin
            ld       = 1'b1;
            ld_data  = DATA_W'(CODE_OVR);
            ld_cnt   = KC_W'(1);
            ld_first = !sent_q;
            ld_last  = 1'b1;
            ld_err   = 1'b1;
            state_d  = ST_HDR;
          end else begin
            if (n_pay != '0) begin
              ld       = 1'b1;
              ld_data  = s_tdata_i;
              ld_cnt   = n_pay;
              ld_first = !sent_q;
              ld_last  = pay_last;
              sent_d   = 1'b1;
            end
            rem_d = rem_next;
            if (frame_end) state_d = ST_HDR;
          end
        end
        ST_DROP: begin
          if (s_tlast_i) state_d = ST_HDR;
        end
        default: state_d = ST_HDR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      rem_q   <= '0;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      sent_q  <= sent_d;
    end
  end

  rxd_byte_ser #(.WB(WB), .KC_W(KC_W)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(ld), .ld_data_i(ld_data), .ld_cnt_i(ld_cnt),
    .ld_first_i(ld_first), .ld_last_i(ld_last), .ld_err_i(ld_err),
    .ready_o(ser_ready),
    .m_tdata_o(m_tdata_o), .m_tvalid_o(m_tvalid_o), .m_tready_i(m_tready_i),
    .m_tfirst_o(m_tfirst_o), .m_tlast_o(m_tlast_o), .m_terr_o(m_terr_o)
  );

  // R4
  abort_closes_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && m_terr_o) |-> m_tlast_o);

  // R8
  end_resyncs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_tvalid_i && s_tready_o && s_tlast_i) |=> (state_q == ST_HDR));

  // R3
  body_has_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BODY) |-> (rem_q != '0));

  // R1
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !m_tvalid_o);
endmodule

// File: tb/sim_rxd_deframer.sv
`timescale 1ns/1ps
module sim_rxd_deframer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] s_tdata = '0;
  logic [3:0]  s_tkeep = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tlast = 1'b0;
  logic        s_tready;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic        m_tfirst, m_tlast, m_terr;

  rxd_deframer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .s_tdata_i(s_tdata), .s_tkeep_i(s_tkeep), .s_tvalid_i(s_tvalid),
    .s_tlast_i(s_tlast), .s_tready_o(s_tready),
    .m_tdata_o(m_tdata), .m_tvalid_o(m_tvalid), .m_tready_i(m_tready),
    .m_tfirst_o(m_tfirst), .m_tlast_o(m_tlast), .m_terr_o(m_terr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int rdy_mode = 0;
  logic [7:0] tx [0:511];
  int wpos = 0;
  logic [10:0] exp_q [$];
  string tag_q [$];
  logic hold_pend = 1'b0;
  logic [10:0] held = '0;
  logic [10:0] got, want;
  string wtag;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      1: m_tready = (cyc % 2) == 0;
      2: m_tready = (cyc % 3) != 0;
      default: m_tready = 1'b1;
    endcase
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      got = {m_terr, m_tfirst, m_tlast, m_tdata};
      if (hold_pend) chk(m_tvalid && (got == held), "R10", {21'd0, got}, {21'd0, held});
      hold_pend = m_tvalid && !m_tready;
      held = got;
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) chk(1'b0, "R9", {21'd0, got}, 32'hFFFF);
        else begin
          want = exp_q.pop_front();
          wtag = tag_q.pop_front();
          chk(got == want, wtag, {21'd0, got}, {21'd0, want});
        end
      end
    end
  end

  task automatic push(input bit e, input bit f, input bit l, input logic [7:0] d,
                      input string tag);
    exp_q.push_back({e, f, l, d});
    tag_q.push_back(tag);
  endtask

  task automatic clear_tx();
    for (int i = 0; i < 512; i++) tx[i] = 8'h00;
    wpos = 0;
  endtask

  task automatic put_frame(input int len, input bit es, input logic [31:0] noise);
    logic [31:0] sw;
    sw = (32'(len) << 16) | (32'(es) << 15) | (noise & 32'hC000_7FFF);
    for (int b = 0; b < 4; b++) tx[wpos + b] = sw[8*b +: 8];
    for (int k = 0; k < len; k++)
      tx[wpos + 4 + k] = (k < len - 4) ? 8'(wpos * 13 + k * 7 + 1) : 8'hEE;
    for (int k = len; k < ((len + 3) / 4) * 4; k++) tx[wpos + 4 + k] = 8'hA5;
    wpos = wpos + 4 + ((len + 3) / 4) * 4;
  endtask

  // byte-level expectation from the requirements
  task automatic model(input int total, input string tag);
    int pos, len, lws;
    bit any;
    logic [31:0] sw;
    pos = 0;
    while (pos < total) begin
      if (total - pos < 4) begin push(1, 1, 1, 8'h02, tag); break; end
      sw = {tx[pos+3], tx[pos+2], tx[pos+1], tx[pos]};
      len = int'(sw[29:16]);
      if (sw[15]) begin push(1, 1, 1, 8'h01, tag); break; end
      if (len < 5) begin push(1, 1, 1, 8'h04, tag); break; end
      if (len > total - pos - 4) begin
        lws = ((total - 1) / 4) * 4;
        any = 1'b0;
        for (int k = 0; k < len - 4; k++)
          if (pos + 4 + k < lws) begin
            push(0, !any, k == len - 5, tx[pos + 4 + k], tag);
            any = 1'b1;
          end
        push(1, !any, 1, 8'h03, tag);
        break;
      end
      for (int k = 0; k < len - 4; k++) push(0, k == 0, k == len - 5, tx[pos + 4 + k], tag);
      pos = pos + 4 + ((len + 3) / 4) * 4;
    end
  endtask

  task automatic send(input int total, input bit gaps);
    int nw, kc;
    nw = (total + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      if (gaps && (w % 3 == 1)) begin s_tvalid = 1'b0; @(posedge clk); #1; end
      kc = total - 4 * w;
      s_tdata  = {tx[4*w+3], tx[4*w+2], tx[4*w+1], tx[4*w]};
      s_tlast  = (w == nw - 1);
      s_tkeep  = (w == nw - 1 && kc < 4) ? 4'((1 << kc) - 1) : 4'hF;
      s_tvalid = 1'b1;
      @(negedge clk);
      while (!s_tready) @(negedge clk);
      @(posedge clk); #1;
      s_tvalid = 1'b0;
      s_tlast  = 1'b0;
    end
  endtask

  task automatic run_case(input int total, input string tag, input bit gaps);
    int t;
    model(total, tag);
    send(total, gaps);
    t = 0;
    while (exp_q.size() != 0 && t < 4000) begin @(negedge clk); t++; end
    if (exp_q.size() != 0) begin
      chk(1'b0, tag, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
    end
    repeat (8) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", cyc, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle output, ready input
    chk(m_tvalid == 1'b0, "R1", {31'd0, m_tvalid}, 0);
    chk(s_tready == 1'b1, "R1", {31'd0, s_tready}, 1);
    @(posedge clk); #1;

    // R2: single frame sweep under three sink patterns, status noise
    for (int m = 0; m < 3; m++) begin
      rdy_mode = m;
      for (int l = 5; l <= 40; l++) begin
        clear_tx(); put_frame(l, 0, 32'(l) * 32'h0101_0101);
        run_case(wpos, "R2", m == 1);
      end
    end
    rdy_mode = 0;

    // R9: transfer ends exactly at the last check byte, no padding
    for (int l = 5; l <= 16; l++) begin
      clear_tx(); put_frame(l, 0, 0);
      run_case(4 + l, "R9", 0);
    end

    // R3: two and three packed frames
    for (int a = 5; a <= 16; a++)
      for (int b = 5; b <= 16; b++) begin
        rdy_mode = (a + b) % 3;
        clear_tx(); put_frame(a, 0, 0); put_frame(b, 0, 32'hFFFF_FFFF);
        run_case(wpos, "R3", b[0]);
      end
    for (int a = 5; a <= 12; a++) begin
      clear_tx(); put_frame(a, 0, 0); put_frame(a + 3, 0, 0); put_frame(17 - a, 0, 0);
      run_case(wpos, "R3", 1);
    end
    rdy_mode = 0;

    // R4 / R8: error flag aborts, rest dropped, next transfer parsed
    clear_tx(); put_frame(10, 1, 0); put_frame(12, 0, 0);
    run_case(wpos, "R4", 0);
    clear_tx(); put_frame(9, 0, 0);
    run_case(wpos, "R8", 0);
    clear_tx(); put_frame(7, 0, 0); put_frame(6, 1, 0); put_frame(8, 0, 0);
    run_case(wpos, "R4", 0);
    clear_tx(); put_frame(13, 0, 0); put_frame(5, 0, 0);
    run_case(wpos, "R8", 0);

    // R5: truncated status word at the tail
    for (int l = 5; l <= 12; l++)
      for (int kc = 1; kc <= 3; kc++) begin
        clear_tx(); put_frame(l, 0, 0);
        tx[wpos] = 8'h11; tx[wpos + 1] = 8'h22; tx[wpos + 2] = 8'h0A;
        run_case(wpos + kc, "R5", 0);
      end

    // R6: transfer cut inside a frame, every cut point
    for (int l = 5; l <= 24; l++)
      for (int t = 4; t < 4 + l; t++) begin
        rdy_mode = t % 3;
        clear_tx(); put_frame(l, 0, 0);
        run_case(t, "R6", 0);
      end
    for (int t = 12; t < 24; t++) begin
      clear_tx(); put_frame(8, 0, 0); put_frame(12, 0, 0);
      run_case(t, "R6", 1);
    end
    rdy_mode = 0;

    // R7: runt lengths, mid-transfer and alone
    for (int l = 0; l <= 4; l++) begin
      clear_tx(); put_frame(l, 0, 0); put_frame(10, 0, 0);
      run_case(wpos, "R7", 0);
      clear_tx(); put_frame(6, 0, 0); put_frame(l, 0, 0); put_frame(10, 0, 0);
      run_case(wpos, "R7", 0);
    end

    // R11: fault priority
    clear_tx(); put_frame(3, 1, 0); put_frame(9, 0, 0);
    run_case(wpos, "R11", 0);
    clear_tx(); put_frame(3, 0, 0);
    run_case(4, "R11", 0);
    clear_tx(); put_frame(40, 1, 0);
    run_case(4, "R11", 0);
    clear_tx(); put_frame(9, 0, 0);
    tx[wpos] = 8'h00; tx[wpos + 1] = 8'h80; tx[wpos + 2] = 8'h02;
    run_case(wpos + 3, "R11", 0);
    clear_tx(); put_frame(9, 0, 0);
    tx[wpos] = 8'h00; tx[wpos + 1] = 8'h80;
    run_case(wpos + 2, "R11", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule